// File: doc/BRIEF.md
# ECC Chunk Status Tally

This block sits behind a page-oriented error-correction engine and folds the per-chunk status codes of one page into a page verdict. A page arrives as a run of accepted chunk codes, one code per cycle in which `chunk_valid` is high. The first code of a page carries `page_first` and the last one carries `page_last`. Idle cycles may fall anywhere inside or between pages.

Each 8-bit code falls into one of four classes:
- **clean:** the code is zero.
- **erased:** the code is all ones.
- **uncorrectable:** the code is the reserved uncorrectable value, or any value above the correction limit other than the erased value.
- **corrected:** any other value, which is the number of bit flips the engine repaired in that chunk.

For each page the block keeps the largest per-chunk flip count, the saturating sum of all flip counts and a saturating count of uncorrectable chunks. When the last chunk is accepted, the block registers the page result and pulses `page_done` for one cycle. If any chunk was uncorrectable, the result is marked failed and the maximum-flip value is reported as zero in its place.

Top module: `ecc_chunk_tally`

## Requirements
- R1: An accepted code 0x00 leaves the page maximum, total and uncorrectable count unchanged.
- R2: An accepted code 0xFF (erased) is treated like a clean chunk: it adds nothing to the maximum, the total or the uncorrectable count.
- R3: An accepted code 0xFE, or any code above CORR_LIMIT (default 0x28) other than 0xFF, adds one to the uncorrectable count, which saturates at all ones.
- R4: An accepted code from 1 to CORR_LIMIT is added to the page total and raises the page maximum when it is larger than the maximum so far.
- R5: A page with at least one uncorrectable chunk reports `page_failed`=1 and `page_max_flips`=0. A page with none reports `page_failed`=0 and its true maximum.
- R6: A chunk accepted with `page_first`=1 starts the counts afresh, and that chunk's own contribution is counted in the same cycle, even when the previous page ended in the cycle just before.
- R7: The page total saturates at 2^SUM_W-1 instead of wrapping.
- R8: `page_done` is high for exactly the one cycle after the clock edge that accepts a chunk with `page_last`=1. The result outputs change only at that edge and hold until the next page completes.
- R9: While `chunk_valid` is low, `chunk_code`, `page_first` and `page_last` have no effect on any count or output.
- R10: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chunk_valid | input | 1 | A chunk status code is presented this cycle |
| chunk_code | input | CODE_W | Status code of the presented chunk |
| page_first | input | 1 | Presented chunk is the first of its page |
| page_last | input | 1 | Presented chunk is the last of its page |
| page_done | output | 1 | One-cycle strobe: page result is updated |
| page_failed | output | 1 | Page had at least one uncorrectable chunk |
| page_max_flips | output | CODE_W | Largest per-chunk flip count, zero when failed |
| page_total_flips | output | SUM_W | Saturating sum of flip counts in the page |
| page_bad_chunks | output | CNT_W | Saturating count of uncorrectable chunks |

## Verification
The main function is driven from a table of pages, each built to isolate one kind of code:
- **All clean or all erased:** zero results here show that 0x00 and 0xFF never reach the counts.
- **Mixed corrected values:** these separate the maximum from the sum.
- **The limit value 0x28 beside 0x29:** this pair pins the correctable boundary.
- **Pages mixing 0xFE, other large codes and erased chunks:** these show that failure masks the maximum while the total still counts the corrected chunks.

Idle bubbles carrying page markers and the uncorrectable code are inserted inside pages to show that unqualified inputs are ignored. Directed runs then check three further cases:
- Back-to-back single-chunk pages, for the restart behaviour.
- Long pages that drive the total and the uncorrectable count into saturation.
- The reset state.

// File: rtl/chunk_tally_pkg.sv
package chunk_tally_pkg;

   // Class of one chunk status code
   typedef enum logic [1:0] {
      CLS_CLEAN  = 2'd0,
      CLS_ERASED = 2'd1,
      CLS_FIXED  = 2'd2,
      CLS_BAD    = 2'd3
   } chunk_cls_e;

endpackage

// File: rtl/chunk_sat_add.sv
// Saturating adder: y = min(a + b, 2^W - 1)
module chunk_sat_add #(
   parameter int unsigned W    = 10,
   parameter int unsigned IN_W = 8
) (
   input  logic [W-1:0]    a,
   input  logic [IN_W-1:0] b,
   output logic [W-1:0]    y
);
   initial begin : p_param_check
      assert (IN_W >= 1 && IN_W <= W)
         else $error("chunk_sat_add: IN_W must be in 1..W");
   end

   logic [W-1:0] b_ext;
   logic [W:0]   wide;

   generate
      if (IN_W < W) begin : g_pad
         assign b_ext = {{(W-IN_W){1'b0}}, b};
      end else begin : g_direct
         assign b_ext = b;
      end
   endgenerate

   assign wide = {1'b0, a} + {1'b0, b_ext};
   assign y    = wide[W] ? {W{1'b1}} : wide[W-1:0];
endmodule

// File: rtl/chunk_code_classifier.sv
// Sorts one status code into its class and extracts the flip count
module chunk_code_classifier
   import chunk_tally_pkg::*;
#(
   parameter int unsigned CODE_W      = 8,
   parameter int unsigned CORR_LIMIT  = 'h28,
   parameter int unsigned ERASED_CODE = 'hFF,
   parameter int unsigned UNCORR_CODE = 'hFE
) (
   input  logic [CODE_W-1:0] code,
   output chunk_cls_e        cls,
   output logic [CODE_W-1:0] flips
);
   localparam logic [CODE_W-1:0] LIMIT_V  = CODE_W'(CORR_LIMIT);
   localparam logic [CODE_W-1:0] ERASED_V = CODE_W'(ERASED_CODE);
   localparam logic [CODE_W-1:0] UNCORR_V = CODE_W'(UNCORR_CODE);

   initial begin : p_param_check
      assert (CORR_LIMIT >= 1 && CORR_LIMIT < UNCORR_CODE && CORR_LIMIT < ERASED_CODE)
         else $error("chunk_code_classifier: limit must sit below the reserved codes");
      assert (ERASED_CODE != UNCORR_CODE && ERASED_CODE < (1 << CODE_W))
         else $error("chunk_code_classifier: reserved codes must differ and fit");
   end

   // Erased outranks the out-of-range test, the reserved code outranks the count
   always_comb begin
      if (code == '0) begin
         cls = CLS_CLEAN;
      end else if (code == ERASED_V) begin
         cls = CLS_ERASED;
      end else if (code == UNCORR_V || code > LIMIT_V) begin
         cls = CLS_BAD;
      end else begin
         cls = CLS_FIXED;
      end
   end

   assign flips = (cls == CLS_FIXED) ? code : '0;
endmodule

// File: rtl/chunk_tally_accum.sv
// Running per-page maximum, saturating sum and saturating bad-chunk count
module chunk_tally_accum
   import chunk_tally_pkg::*;
#(
   parameter int unsigned CODE_W     = 8,
   parameter int unsigned CORR_LIMIT = 'h28,
   parameter int unsigned SUM_W      = 10,
   parameter int unsigned CNT_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              restart,
   input  chunk_cls_e        cls,
   input  logic [CODE_W-1:0] flips,
   output logic [CODE_W-1:0] max_q,
   output logic [SUM_W-1:0]  sum_q,
   output logic [CNT_W-1:0]  bad_q,
   output logic [CODE_W-1:0] max_nxt,
   output logic [SUM_W-1:0]  sum_nxt,
   output logic [CNT_W-1:0]  bad_nxt
);
   initial begin : p_param_check
      assert (SUM_W >= CODE_W) else $error("chunk_tally_accum: SUM_W < CODE_W");
      assert (CNT_W >= 1)      else $error("chunk_tally_accum: CNT_W must be positive");
   end

   logic [CODE_W-1:0] base_max;
   logic [SUM_W-1:0]  base_sum, sum_add;
   logic [CNT_W-1:0]  base_bad, bad_add;
   logic              is_bad;

   // A page start discards the previous page within the same cycle
   assign base_max = restart ? '0 : max_q;
   assign base_sum = restart ? '0 : sum_q;
   assign base_bad = restart ? '0 : bad_q;
   assign is_bad   = (cls == CLS_BAD);

   chunk_sat_add #(.W(SUM_W), .IN_W(CODE_W)) i_sum_add (
      .a(base_sum), .b(flips), .y(sum_add)
   );

   chunk_sat_add #(.W(CNT_W), .IN_W(1)) i_bad_add (
      .a(base_bad), .b(is_bad), .y(bad_add)
   );

   always_comb begin
      if (take) begin
         max_nxt = (flips > base_max) ? flips : base_max;
         sum_nxt = sum_add;
         bad_nxt = bad_add;
      end else begin
         max_nxt = max_q;
         sum_nxt = sum_q;
         bad_nxt = bad_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         max_q <= '0;
         sum_q <= '0;
         bad_q <= '0;
      end else begin
         max_q <= max_nxt;
         sum_q <= sum_nxt;
         bad_q <= bad_nxt;
      end
   end

   // R4: the running maximum never exceeds the correction limit
   assert_max_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      max_q <= CODE_W'(CORR_LIMIT));

   // R7: a saturated total stays saturated within the page
   assert_sum_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !restart && (&sum_q)) |=> (&sum_q));

   // R3: an uncorrectable chunk opening a page leaves a count of one
   assert_bad_first_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (take && restart && cls == CLS_BAD) |=> (bad_q == CNT_W'(1)));
endmodule

// File: rtl/chunk_tally_report.sv
// Captures the page result at the last chunk and raises the done strobe
module chunk_tally_report #(
   parameter int unsigned CODE_W = 8,
   parameter int unsigned SUM_W  = 10,
   parameter int unsigned CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              finish,
   input  logic [CODE_W-1:0] max_nxt,
   input  logic [SUM_W-1:0]  sum_nxt,
   input  logic [CNT_W-1:0]  bad_nxt,
   output logic              done,
   output logic              failed,
   output logic [CODE_W-1:0] max_out,
   output logic [SUM_W-1:0]  sum_out,
   output logic [CNT_W-1:0]  bad_out
);
   logic capture, any_bad;

   assign capture = take && finish;
   assign any_bad = (bad_nxt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done    <= 1'b0;
         failed  <= 1'b0;
         max_out <= '0;
         sum_out <= '0;
         bad_out <= '0;
      end else begin
         done <= capture;
         if (capture) begin
            failed  <= any_bad;
            max_out <= any_bad ? '0 : max_nxt;
            sum_out <= sum_nxt;
            bad_out <= bad_nxt;
         end
      end
   end

   // R8: the strobe only follows an accepted last chunk
   assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(take && finish));

   // R8: results hold between completions
   assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> ($stable(max_out) && $stable(sum_out) && $stable(bad_out) && $stable(failed)));

   // R5: a failed page never exposes a maximum
   assert_fail_masks_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
      failed |-> (max_out == '0));
endmodule

// File: rtl/ecc_chunk_tally.sv
module ecc_chunk_tally
   import chunk_tally_pkg::*;
#(
   parameter int unsigned CODE_W      = 8,
   parameter int unsigned CORR_LIMIT  = 'h28,
   parameter int unsigned ERASED_CODE = 'hFF,
   parameter int unsigned UNCORR_CODE = 'hFE,
   parameter int unsigned SUM_W       = 10,
   parameter int unsigned CNT_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chunk_valid,
   input  logic [CODE_W-1:0] chunk_code,
   input  logic              page_first,
   input  logic              page_last,
   output logic              page_done,
   output logic              page_failed,
   output logic [CODE_W-1:0] page_max_flips,
   output logic [SUM_W-1:0]  page_total_flips,
   output logic [CNT_W-1:0]  page_bad_chunks
);
   chunk_cls_e        cls;
   logic [CODE_W-1:0] flips;
   logic [CODE_W-1:0] acc_max, nxt_max;
   logic [SUM_W-1:0]  acc_sum, nxt_sum;
   logic [CNT_W-1:0]  acc_bad, nxt_bad;

   chunk_code_classifier #(
      .CODE_W(CODE_W), .CORR_LIMIT(CORR_LIMIT),
      .ERASED_CODE(ERASED_CODE), .UNCORR_CODE(UNCORR_CODE)
   ) i_classify (
      .code(chunk_code), .cls(cls), .flips(flips)
   );

   chunk_tally_accum #(
      .CODE_W(CODE_W), .CORR_LIMIT(CORR_LIMIT), .SUM_W(SUM_W), .CNT_W(CNT_W)
   ) i_accum (
      .clk(clk), .rst_n(rst_n), .take(chunk_valid), .restart(page_first),
      .cls(cls), .flips(flips),
      .max_q(acc_max), .sum_q(acc_sum), .bad_q(acc_bad),
      .max_nxt(nxt_max), .sum_nxt(nxt_sum), .bad_nxt(nxt_bad)
   );

   chunk_tally_report #(
      .CODE_W(CODE_W), .SUM_W(SUM_W), .CNT_W(CNT_W)
   ) i_report (
      .clk(clk), .rst_n(rst_n), .take(chunk_valid), .finish(page_last),
      .max_nxt(nxt_max), .sum_nxt(nxt_sum), .bad_nxt(nxt_bad),
      .done(page_done), .failed(page_failed), .max_out(page_max_flips),
      .sum_out(page_total_flips), .bad_out(page_bad_chunks)
   );

   // R1: a zero code inside a page changes no count
   assert_zero_no_effect_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (chunk_valid && !page_first && chunk_code == '0)
      |=> ($stable(acc_max) && $stable(acc_sum) && $stable(acc_bad)));

   // R2: an erased code inside a page changes no count
   assert_erased_no_effect_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (chunk_valid && !page_first && chunk_code == CODE_W'(ERASED_CODE))
      |=> ($stable(acc_max) && $stable(acc_sum) && $stable(acc_bad)));

   // R9: idle cycles touch nothing and raise no strobe
   assert_idle_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !chunk_valid |=> ($stable(acc_max) && $stable(acc_sum) && $stable(acc_bad) && !page_done));
endmodule

// File: tb/test_ecc_chunk_tally.sv
module test_ecc_chunk_tally;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chunk_valid = 1'b0;
   logic [7:0] chunk_code = 8'h00;
   logic       page_first = 1'b0;
   logic       page_last = 1'b0;
   logic       page_done, page_failed;
   logic [7:0] page_max_flips;
   logic [9:0] page_total_flips;
   logic [3:0] page_bad_chunks;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   ecc_chunk_tally i_ecc_chunk_tally (
      .clk(clk), .rst_n(rst_n), .chunk_valid(chunk_valid), .chunk_code(chunk_code),
      .page_first(page_first), .page_last(page_last), .page_done(page_done),
      .page_failed(page_failed), .page_max_flips(page_max_flips),
      .page_total_flips(page_total_flips), .page_bad_chunks(page_bad_chunks)
   );

   // One page per entry: chunk count, codes (byte 0 first), expected results
   typedef struct packed {
      logic [2:0]  n;
      logic [31:0] codes;
      logic [7:0]  emax;
      logic [9:0]  etot;
      logic [3:0]  ebad;
      logic        efail;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{3'd1, 32'h00000000, 8'd0,  10'd0,  4'd0, 1'b0},  // R1 clean only
      '{3'd2, 32'h000000FF, 8'd0,  10'd0,  4'd0, 1'b0},  // R2 erased + clean
      '{3'd3, 32'h00030C05, 8'd12, 10'd20, 4'd0, 1'b0},  // R4 max vs sum
      '{3'd2, 32'h00000128, 8'd40, 10'd41, 4'd0, 1'b0},  // R4 limit value
      '{3'd2, 32'h00000429, 8'd0,  10'd4,  4'd1, 1'b1},  // R3 R5 limit + 1
      '{3'd3, 32'h0007FFFE, 8'd0,  10'd7,  4'd1, 1'b1},  // R3 reserved code
      '{3'd4, 32'hFF0180FE, 8'd0,  10'd1,  4'd2, 1'b1},  // R3 two bad
      '{3'd4, 32'h0200FF02, 8'd2,  10'd4,  4'd0, 1'b0}   // R2 R4 mixed
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] c, input logic f, input logic l);
      @(negedge clk);
      chunk_valid = 1'b1; chunk_code = c; page_first = f; page_last = l;
   endtask

   // Idle bubble with junk on the qualified inputs (R9)
   task automatic bubble();
      @(negedge clk);
      chunk_valid = 1'b0; chunk_code = 8'hFE; page_first = 1'b1; page_last = 1'b1;
   endtask

   task automatic expect_result(input string tag, input int emax, input int etot,
                                input int ebad, input int efail);
      chk({tag, " R4 max"},   int'(page_max_flips),   emax);
      chk({tag, " R4 total"}, int'(page_total_flips), etot);
      chk({tag, " R3 bad"},   int'(page_bad_chunks),  ebad);
      chk({tag, " R5 failed"}, int'(page_failed),     efail);
   endtask

   initial begin : p_watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : p_main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 done", int'(page_done), 0);
      expect_result("R10", 0, 0, 0, 0);

      // Table walk, bubbles between odd chunks
      for (int v = 0; v < NV; v++) begin
         for (int i = 0; i < int'(VECS[v].n); i++) begin
            if (i % 2 == 1) bubble();
            send(VECS[v].codes[8*i +: 8], i == 0, i == int'(VECS[v].n) - 1);
         end
         @(negedge clk);
         chunk_valid = 1'b0; page_first = 1'b0; page_last = 1'b0;
         chk($sformatf("R8 done vec %0d", v), int'(page_done), 1);
         expect_result($sformatf("R1/R2/R3/R4/R5 vec %0d", v), int'(VECS[v].emax),
                       int'(VECS[v].etot), int'(VECS[v].ebad), int'(VECS[v].efail));
         @(negedge clk);
         chk($sformatf("R8 pulse end vec %0d", v), int'(page_done), 0);
         chk($sformatf("R8 hold vec %0d", v), int'(page_total_flips), int'(VECS[v].etot));
      end

      // R9: idle cycles with markers and codes raise nothing, change nothing
      bubble();
      bubble();
      @(negedge clk);
      chunk_valid = 1'b0;
      chk("R9 no done", int'(page_done), 0);
      chk("R9 total unchanged", int'(page_total_flips), int'(VECS[NV-1].etot));

      // R6: back-to-back single-chunk pages
      send(8'h10, 1'b1, 1'b1);
      send(8'h03, 1'b1, 1'b1);
      chk("R6 first page done", int'(page_done), 1);
      chk("R6 first page max", int'(page_max_flips), 16);
      @(negedge clk);
      chunk_valid = 1'b0; page_first = 1'b0; page_last = 1'b0;
      chk("R6 second page done", int'(page_done), 1);
      chk("R6 restart max", int'(page_max_flips), 3);
      chk("R6 restart total", int'(page_total_flips), 3);

      // R7: 26 x 40 = 1040 exceeds 1023
      for (int i = 0; i < 26; i++) send(8'h28, i == 0, i == 25);
      @(negedge clk);
      chunk_valid = 1'b0; page_first = 1'b0; page_last = 1'b0;
      chk("R7 done", int'(page_done), 1);
      expect_result("R7 saturate", 40, 1023, 0, 0);

      // R3: 17 uncorrectable chunks saturate the count at 15
      for (int i = 0; i < 17; i++) send(8'hFE, i == 0, i == 16);
      @(negedge clk);
      chunk_valid = 1'b0; page_first = 1'b0; page_last = 1'b0;
      chk("R3 done", int'(page_done), 1);
      expect_result("R3 count saturate", 0, 0, 15, 1);

      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule